// File: doc/BRIEF.md
# SDRAM Auto Refresh Scheduler

This block decides when an SDRAM controller must spend command slots on AUTO REFRESH so that every row is refreshed inside the retention window. A free-running tick counter, sized from the clock frequency, adds refreshes to an internal owed count. The block then asks the command arbiter for the bus and issues refreshes until nothing is owed. Each refresh is its own command. The row address is produced inside the device, so the block drives no address.

Two schedules are supported, chosen by `burst_mode`. In distributed mode one refresh becomes owed every refresh interval (7.81 µs by default). Up to `DEBT_MAX` refreshes may be postponed, and `urgent` is raised once the backlog reaches `URGENT_LVL`. In burst mode the whole set of `NUM_REFRESH` refreshes becomes owed once per retention period (64 ms by default). They are then issued back to back, spaced by the refresh cycle time.

Before a refresh, all banks must be closed. If `banks_idle` is low, the block first asks for a precharge-all and waits the precharge time after its grant. Only then does it request the refresh itself. Each request is held until it is granted.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is asserted and until the first refresh becomes owed, `ref_req`, `pre_all_req`, `ref_cmd` and `urgent` are all low.
- R2: In distributed mode (`burst_mode`=0) one refresh becomes owed every `INTERVAL_CYC` cycles; with grants given at once, exactly one refresh command follows each interval.
- R3: In burst mode (`burst_mode`=1) no refresh is owed before the first `PERIOD_CYC` cycles have elapsed; at the end of each period `NUM_REFRESH` refreshes become owed and are issued back to back.
- R4: When a refresh is owed and `banks_idle` is low, `pre_all_req` is raised before any `ref_req`; `ref_req` and `pre_all_req` are never high in the same cycle.
- R5: A refresh command comes no sooner than `TRP_CYC` cycles after the cycle in which the precharge-all request was granted.
- R6: Two successive refresh commands are at least `TRFC_CYC` cycles apart.
- R7: A raised `ref_req` or `pre_all_req` stays high until the cycle in which `grant` is high.
- R8: `ref_cmd` is high exactly in the cycle where `ref_req` and `grant` are both high; that refresh is then counted as done, and `ref_req` is low in the following cycle.
- R9: In distributed mode the owed count saturates at `DEBT_MAX`: after a long stall, granting continuously yields exactly `DEBT_MAX` refresh commands before the requests stop.
- R10: `urgent` is high exactly while the owed count is at least `URGENT_LVL`.
- R11: When `banks_idle` is high as a refresh becomes owed, no precharge-all is requested and `ref_req` is raised directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| banks_idle | input | 1 | High when every bank is closed and its precharge time has elapsed |
| grant | input | 1 | Arbiter accepts the request that is up in this cycle |
| burst_mode | input | 1 | 0: distributed schedule, 1: burst schedule |
| ref_req | output | 1 | Request to issue an AUTO REFRESH |
| pre_all_req | output | 1 | Request to issue a precharge of all banks |
| ref_cmd | output | 1 | Strobe: the refresh is issued in this cycle |
| urgent | output | 1 | Owed refreshes have reached the urgency threshold |

## Verification
The assertions take for granted two properties of the environment. The arbiter may grant at any time but never withdraws a request. `banks_idle` is high only once the precharge time has elapsed, and it stays high while a refresh request is pending. The bench follows both rules. It lowers `banks_idle` only while no request is up, and raises it in the cycle after a precharge grant. The precharge-time and refresh-spacing checks then depend only on the block's own counters. The grant delay is taken from a small table so that holding is exercised without stalling past the next interval.

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int CLK_MHZ      = 125,
  parameter int REFI_NS      = 7810,
  parameter int PERIOD_MS    = 64,
  parameter int INTERVAL_CYC = CLK_MHZ * REFI_NS / 1000,
  parameter int PERIOD_CYC   = CLK_MHZ * 1000 * PERIOD_MS,
  parameter int NUM_REFRESH  = 8192,
  parameter int TRP_CYC      = 3,
  parameter int TRFC_CYC     = 9,
  parameter int DEBT_MAX     = 8,
  parameter int URGENT_LVL   = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic banks_idle,
  input  logic grant,
  input  logic burst_mode,
  output logic ref_req,
  output logic pre_all_req,
  output logic ref_cmd,
  output logic urgent
);
  localparam int SPAN    = (PERIOD_CYC > INTERVAL_CYC) ? PERIOD_CYC : INTERVAL_CYC;
  localparam int TICK_W  = $clog2(SPAN + 1);
  localparam int OWE_TOP = (NUM_REFRESH > DEBT_MAX) ? NUM_REFRESH : DEBT_MAX;
  localparam int OWE_W   = $clog2(OWE_TOP + 1);
  localparam int WAIT_TOP = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC;
  localparam int WAIT_W  = $clog2(WAIT_TOP + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_TRP, S_REF, S_TRFC} st_t;

  st_t               st;
  logic [TICK_W-1:0] tick;
  logic [OWE_W-1:0]  owed;
  logic [WAIT_W-1:0] cnt;

  wire [TICK_W-1:0] limit = burst_mode ? TICK_W'(PERIOD_CYC - 1) : TICK_W'(INTERVAL_CYC - 1);
  wire              wrap  = tick >= limit;

  assign ref_req     = (st == S_REF);
  assign pre_all_req = (st == S_PRE);
  assign ref_cmd     = ref_req & grant;
  assign urgent      = owed >= OWE_W'(URGENT_LVL);

  always_ff @(posedge clk) begin
    if (!rst_n) tick <= '0;
    else        tick <= wrap ? '0 : tick + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      owed <= '0;
    else if (wrap && burst_mode)
      owed <= OWE_W'(NUM_REFRESH);
    else if (wrap && !ref_cmd) begin
      if (owed < OWE_W'(DEBT_MAX)) owed <= owed + 1'b1;
    end else if (!wrap && ref_cmd)
      owed <= owed - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (owed != '0) st <= banks_idle ? S_REF : S_PRE;
        S_PRE:
          if (grant) begin
            st  <= S_TRP;
            cnt <= WAIT_W'(TRP_CYC - 2);
          end
        S_TRP:
          if (cnt == '0) st <= S_REF;
          else           cnt <= cnt - 1'b1;
        S_REF:
          if (grant) begin
            st  <= S_TRFC;
            cnt <= WAIT_W'(TRFC_CYC - 2);
          end
        S_TRFC:
          if (cnt == '0) st <= S_IDLE;
          else           cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
  parameter int TRP_CYC  = 3,
  parameter int TRFC_CYC = 9
) (
  input logic clk,
  input logic rst_n,
  input logic banks_idle,
  input logic grant,
  input logic ref_req,
  input logic pre_all_req,
  input logic ref_cmd
);
  localparam int SW = $clog2(TRP_CYC + TRFC_CYC + 2) + 1;

  logic [SW-1:0] since_pre, since_ref;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_pre <= '1;
      since_ref <= '1;
    end else begin
      if (pre_all_req && grant) since_pre <= SW'(1);
      else if (since_pre != '1) since_pre <= since_pre + 1'b1;
      if (ref_cmd)              since_ref <= SW'(1);
      else if (since_ref != '1) since_ref <= since_ref + 1'b1;
    end
  end

  assert_req_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_req && pre_all_req));
  assert_ref_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req && !grant |=> ref_req);
  assert_pre_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all_req && !grant |=> pre_all_req);
  assert_trp_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> since_pre >= SW'(TRP_CYC));
  assert_trfc_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |-> since_ref >= SW'(TRFC_CYC));
  assert_single_issue_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cmd |=> !ref_req);
  assert_pre_only_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pre_all_req) |-> !$past(banks_idle));
endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(
  .TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC)
) chk_i (
  .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .grant(grant),
  .ref_req(ref_req), .pre_all_req(pre_all_req), .ref_cmd(ref_cmd)
);

// File: tb/sdram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module sdram_refresh_sched_tb_top;
  localparam int INTERVAL = 100;
  localparam int PERIOD   = 600;
  localparam int NREF     = 8;
  localparam int TRP      = 3;
  localparam int TRFC     = 5;
  localparam int DEBT     = 4;
  localparam int URG      = 3;

  // {banks_idle, expect_precharge, grant_delay[2:0]}
  localparam logic [4:0] VEC [5] = '{
    {1'b0, 1'b1, 3'd0}, {1'b0, 1'b1, 3'd3}, {1'b1, 1'b0, 3'd2},
    {1'b1, 1'b0, 3'd0}, {1'b0, 1'b1, 3'd5}};

  logic clk = 0, rst_n = 0, banks_idle = 1, grant = 0, burst_mode = 0;
  logic ref_req, pre_all_req, ref_cmd, urgent;
  int cyc = 0, c0 = 0, n_chk = 0, n_fail = 0, n_ref = 0;
  int last_ref = 0, last_pre = 0;
  bit have_ref = 0, have_pre = 0, done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_refresh_sched #(
    .INTERVAL_CYC(INTERVAL), .PERIOD_CYC(PERIOD), .NUM_REFRESH(NREF),
    .TRP_CYC(TRP), .TRFC_CYC(TRFC), .DEBT_MAX(DEBT), .URGENT_LVL(URG)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .banks_idle(banks_idle), .grant(grant),
    .burst_mode(burst_mode), .ref_req(ref_req), .pre_all_req(pre_all_req),
    .ref_cmd(ref_cmd), .urgent(urgent)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (pre_all_req && grant) begin
        last_pre = cyc;
        have_pre = 1;
      end
      if (ref_cmd) begin
        n_ref++;
        if (have_ref) check(cyc - last_ref >= TRFC, "R6 refresh spacing", cyc - last_ref, TRFC);
        if (have_pre) check(cyc - last_pre >= TRP, "R5 precharge to refresh", cyc - last_pre, TRP);
        have_pre = 0;
        have_ref = 1;
        last_ref = cyc;
      end
    end
  end

  task automatic do_reset(input logic burst);
    @(negedge clk);
    rst_n = 0; grant = 0; banks_idle = 1; burst_mode = burst;
    repeat (3) @(negedge clk);
    have_ref = 0; have_pre = 0; n_ref = 0;
    rst_n = 1;
    c0 = cyc;
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int base;
    // R1: reset state
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    #1;
    check({ref_req, pre_all_req, ref_cmd, urgent} == 4'b0, "R1 outputs in reset",
          {ref_req, pre_all_req, ref_cmd, urgent}, 0);
    do_reset(0);
    wait_until(c0 + INTERVAL / 2);
    check({ref_req, pre_all_req, ref_cmd, urgent} == 4'b0, "R1 outputs before first interval",
          {ref_req, pre_all_req, ref_cmd, urgent}, 0);

    // Table walk: distributed mode, various idle states and grant delays
    foreach (VEC[i]) begin
      int to = 0;
      @(negedge clk);
      banks_idle = VEC[i][4];
      while (!(ref_req || pre_all_req) && to < 3 * INTERVAL) begin
        @(negedge clk); to++;
      end
      #1;
      check(pre_all_req == VEC[i][3], "R4/R11 first request is precharge", pre_all_req, VEC[i][3]);
      check(!(ref_req && pre_all_req), "R4 requests exclusive", ref_req && pre_all_req, 0);
      if (pre_all_req) begin
        repeat (VEC[i][2:0]) @(negedge clk);
        #1;
        check(pre_all_req, "R7 precharge request held", pre_all_req, 1);
        @(negedge clk); grant = 1;
        @(negedge clk); grant = 0; banks_idle = 1;
        to = 0;
        while (!ref_req && to < 50) begin
          @(negedge clk); to++;
        end
        #1;
      end
      repeat (VEC[i][2:0]) @(negedge clk);
      #1;
      check(ref_req, "R7 refresh request held", ref_req, 1);
      check(!ref_cmd, "R8 no strobe without grant", ref_cmd, 0);
      @(negedge clk); grant = 1;
      #1;
      check(ref_cmd, "R8 strobe on grant", ref_cmd, 1);
      @(negedge clk); grant = 0;
      #1;
      check(!ref_req, "R8 request drops after issue", ref_req, 0);
    end

    // R2: distributed count with prompt grants
    do_reset(0);
    grant = 1;
    wait_until(c0 + 5 * INTERVAL + 20);
    check(n_ref == 5, "R2 one refresh per interval", n_ref, 5);
    check(!urgent, "R10 no urgency when kept up", urgent, 0);

    // R3: burst schedule
    do_reset(1);
    grant = 1;
    wait_until(c0 + PERIOD - 10);
    check(n_ref == 0, "R3 nothing before first period", n_ref, 0);
    wait_until(c0 + PERIOD + 5);
    check(urgent, "R10 urgent during burst", urgent, 1);
    wait_until(c0 + PERIOD + 100);
    check(n_ref == NREF, "R3 full burst issued", n_ref, NREF);
    check(!urgent, "R10 urgency clears after burst", urgent, 0);
    wait_until(c0 + 2 * PERIOD + 100);
    check(n_ref == 2 * NREF, "R3 second burst issued", n_ref, 2 * NREF);

    // R9/R10: debt build-up, threshold and saturation
    do_reset(0);
    wait_until(c0 + 2 * INTERVAL + 50);
    check(!urgent, "R10 below threshold", urgent, 0);
    wait_until(c0 + 3 * INTERVAL + 50);
    check(urgent, "R10 at threshold", urgent, 1);
    check(n_ref == 0, "R7 no issue without grant", n_ref, 0);
    base = c0 + 9 * INTERVAL + 50;
    wait_until(base);
    grant = 1;
    wait_until(base + 45);
    check(n_ref == DEBT, "R9 owed count saturates", n_ref, DEBT);
    check(!ref_req, "R9 requests stop after backlog", ref_req, 0);
    check(!urgent, "R10 urgency clears", urgent, 0);
    grant = 0;

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule